// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block keeps an asynchronous DRAM alive without help from the main memory controller's address path. After a synchronous reset it stays silent for a programmable start-up delay, then runs a short burst of CAS-before-RAS refresh cycles on its own. Only when that burst has finished does it report the memory as ready for use. No grant is needed during the burst, because the controller must not touch the memory until ready is high.

Once ready, an interval timer spreads the refresh budget evenly over the refresh period. Each expiry adds one refresh to a backlog counter. While the backlog is nonzero and no strobe sequence is running, the block raises a request to the controller. When the controller grants it, the block drives the row and column strobes itself in CAS-before-RAS order, so the memory's internal row counter chooses the row and no address is supplied. If the controller holds back the grant for several intervals, the backlog grows and a separate counter records each interval that expired with refresh work still owed. When grants return, the owed refreshes run back to back. The write strobe is held high throughout, so a refresh can never be taken as a test-mode entry.

Top module: `dram_refresh_sched`

## Requirements
- R1: While `rst` is high and in the cycle after it: `ras_n`, `cas_n` and `we_n` are 1; `ready` and `ref_req` are 0; `backlog` and `missed_total` are 0.
- R2: After `rst` falls, both strobes stay high for the first STARTUP_CYCLES clock cycles. The first `cas_n` fall is visible in cycle STARTUP_CYCLES+1.
- R3: After the start-up delay, exactly INIT_REFRESHES refresh cycles run with `ref_gnt` held low and `ref_req` low. `ready` rises PRECH_CYC+1 cycles after the last of them raises `ras_n`, and it then stays high until reset.
- R4: In every refresh, `cas_n` falls while `ras_n` is high. `cas_n` then stays low with `ras_n` high for SETUP_CYC cycles before `ras_n` falls.
- R5: After `ras_n` falls, both strobes stay low for HOLD_CYC cycles. `cas_n` then rises while `ras_n` stays low for a further RAS_LOW_CYC-HOLD_CYC cycles.
- R6: When `ras_n` rises, `cas_n` is already high. Both stay high for at least PRECH_CYC cycles before `cas_n` can fall again.
- R7: `we_n` is 1 in every cycle.
- R8: While `ready` is high, `backlog` rises by one every REFRESH_INTERVAL cycles. `ref_req` is high only while `ready` is high, `backlog` is nonzero and no strobe sequence is running.
- R9: In the cycle after one in which both `ref_req` and `ref_gnt` are high, `cas_n` is 0, `ref_req` is 0 and `backlog` is one lower.
- R10: With `ref_gnt` held high, a backlog of k is worked off in exactly k refresh cycles. Consecutive cycles are separated by exactly PRECH_CYC+1 cycles with both strobes high. A grant given while `backlog` is 0 starts nothing.
- R11: `missed_total` rises by one for each interval expiry that finds `backlog` already nonzero. It never decreases.
- R12: `backlog` saturates at 2^DEBT_W-1. Further expiries leave it there but still count in `missed_total`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_gnt | input | 1 | Grant from the memory controller for a pending refresh |
| ref_req | output | 1 | Refresh wanted; held until granted |
| ready | output | 1 | Initialization finished; memory usable |
| ras_n | output | 1 | Row strobe to the DRAM, active low |
| cas_n | output | 1 | Column strobe to the DRAM, active low |
| we_n | output | 1 | Write strobe to the DRAM, held high |
| backlog | output | DEBT_W | Refreshes owed and not yet started |
| missed_total | output | MISS_W | Interval expiries that found refresh work still owed (saturating) |

## Verification
The hardest state to reach is a saturated backlog. It needs the grant withheld across more interval expiries than the counter can hold, and at the real refresh interval that would take far too long. The bench therefore shrinks the interval and start-up delay through parameters, withholds the grant for eighteen expiries, and then checks that the stuck counter value and the miss count agree. It then releases the grant and counts the exact number of back-to-back strobe sequences needed to drain the backlog, before the next expiry can add to it.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    // Top-level operating mode of the scheduler.
    typedef enum logic [1:0] {
        MODE_WAIT = 2'd0,   // start-up delay after reset
        MODE_INIT = 2'd1,   // initialization refresh burst
        MODE_RUN  = 2'd2    // periodic refresh on request/grant
    } rfs_mode_e;

    // Phases of one CAS-before-RAS strobe sequence.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,   // column strobe low, row strobe high
        PH_HOLD   = 3'd2,   // both strobes low
        PH_ACTIVE = 3'd3,   // row strobe low, column strobe released
        PH_PRECH  = 3'd4    // both high, row precharge
    } cbr_phase_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
    } strobe_t;

    // Bits needed to hold the values 0 .. n-1.
    function automatic int unsigned width_for(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    // Strobe levels driven in each phase.
    function automatic strobe_t phase_strobes(input cbr_phase_e ph);
        strobe_t s;
        case (ph)
            PH_SETUP:  s = '{ras_n: 1'b1, cas_n: 1'b0};
            PH_HOLD:   s = '{ras_n: 1'b0, cas_n: 1'b0};
            PH_ACTIVE: s = '{ras_n: 1'b0, cas_n: 1'b1};
            default:   s = '{ras_n: 1'b1, cas_n: 1'b1};
        endcase
        return s;
    endfunction

    // Phase that follows a completed phase.
    function automatic cbr_phase_e phase_after(input cbr_phase_e ph);
        cbr_phase_e n;
        case (ph)
            PH_SETUP:  n = PH_HOLD;
            PH_HOLD:   n = PH_ACTIVE;
            PH_ACTIVE: n = PH_PRECH;
            default:   n = PH_IDLE;
        endcase
        return n;
    endfunction

    // Saturating increment for an unsigned counter of up to 32 bits.
    function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] max_v);
        return (v == max_v) ? v : v + 32'd1;
    endfunction

endpackage

// File: rtl/rfs_tick_gen.sv
module rfs_tick_gen
    import rfs_pkg::*;
#(
    parameter int unsigned INTERVAL = 1953
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    output logic tick
);
    localparam int unsigned CW = width_for(INTERVAL);
    localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt_q;

    // One-cycle pulse at the end of every interval while enabled.
    assign tick = enable && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/rfs_backlog.sv
module rfs_backlog
    import rfs_pkg::*;
#(
    parameter int unsigned DEBT_W = 4,
    parameter int unsigned MISS_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              take,
    output logic [DEBT_W-1:0] debt,
    output logic [MISS_W-1:0] missed
);
    localparam logic [DEBT_W-1:0] DEBT_MAX = {DEBT_W{1'b1}};
    localparam logic [MISS_W-1:0] MISS_MAX = {MISS_W{1'b1}};

    logic [DEBT_W-1:0] debt_q;
    logic [MISS_W-1:0] miss_q;
    logic [DEBT_W-1:0] debt_d;
    logic [MISS_W-1:0] miss_d;

    always_comb begin
        debt_d = debt_q;
        case ({tick, take})
            2'b10:   debt_d = DEBT_W'(sat_inc(32'(debt_q), 32'(DEBT_MAX)));
            2'b01:   debt_d = (debt_q == '0) ? debt_q : debt_q - 1'b1;
            default: debt_d = debt_q;   // idle, or one added and one taken
        endcase

        // An expiry that finds work still owed is a missed slot.
        miss_d = miss_q;
        if (tick && (debt_q != '0)) begin
            miss_d = MISS_W'(sat_inc(32'(miss_q), 32'(MISS_MAX)));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            debt_q <= '0;
            miss_q <= '0;
        end else begin
            debt_q <= debt_d;
            miss_q <= miss_d;
        end
    end

    assign debt   = debt_q;
    assign missed = miss_q;

endmodule

// File: rtl/rfs_cbr_seq.sv
module rfs_cbr_seq
    import rfs_pkg::*;
#(
    parameter int unsigned SETUP_CYC   = 1,
    parameter int unsigned HOLD_CYC    = 2,
    parameter int unsigned RAS_LOW_CYC = 9,
    parameter int unsigned PRECH_CYC   = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic ras_n,
    output logic cas_n
);
    localparam int unsigned ACTIVE_CYC = RAS_LOW_CYC - HOLD_CYC;
    localparam int unsigned MAX_A  = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
    localparam int unsigned MAX_B  = (ACTIVE_CYC > PRECH_CYC) ? ACTIVE_CYC : PRECH_CYC;
    localparam int unsigned MAX_L  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned CW     = width_for(MAX_L);

    localparam logic [CW-1:0] SETUP_LAST  = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] HOLD_LAST   = CW'(HOLD_CYC - 1);
    localparam logic [CW-1:0] ACTIVE_LAST = CW'(ACTIVE_CYC - 1);
    localparam logic [CW-1:0] PRECH_LAST  = CW'(PRECH_CYC - 1);

    cbr_phase_e    phase_q, phase_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] last_cnt;
    strobe_t       pins_q;

    always_comb begin
        case (phase_q)
            PH_SETUP:  last_cnt = SETUP_LAST;
            PH_HOLD:   last_cnt = HOLD_LAST;
            PH_ACTIVE: last_cnt = ACTIVE_LAST;
            PH_PRECH:  last_cnt = PRECH_LAST;
            default:   last_cnt = '0;
        endcase
    end

    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        if (phase_q == PH_IDLE) begin
            cnt_d = '0;
            if (start) begin
                phase_d = PH_SETUP;
            end
        end else if (cnt_q == last_cnt) begin
            phase_d = phase_after(phase_q);
            cnt_d   = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    // Strobes come straight from flops, aligned with the phase register.
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            pins_q  <= phase_strobes(PH_IDLE);
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
            pins_q  <= phase_strobes(phase_d);
        end
    end

    assign busy  = (phase_q != PH_IDLE);
    assign ras_n = pins_q.ras_n;
    assign cas_n = pins_q.cas_n;

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import rfs_pkg::*;
#(
    parameter int unsigned STARTUP_CYCLES   = 25000,
    parameter int unsigned INIT_REFRESHES   = 8,
    parameter int unsigned REFRESH_INTERVAL = 1953,
    parameter int unsigned SETUP_CYC        = 1,
    parameter int unsigned HOLD_CYC         = 2,
    parameter int unsigned RAS_LOW_CYC      = 9,
    parameter int unsigned PRECH_CYC        = 7,
    parameter int unsigned DEBT_W           = 4,
    parameter int unsigned MISS_W           = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_gnt,
    output logic              ref_req,
    output logic              ready,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [DEBT_W-1:0] backlog,
    output logic [MISS_W-1:0] missed_total
);
    localparam int unsigned WAIT_W = width_for(STARTUP_CYCLES);
    localparam int unsigned INIT_W = width_for(INIT_REFRESHES + 1);
    localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(STARTUP_CYCLES - 1);
    localparam logic [INIT_W-1:0] INIT_LOAD = INIT_W'(INIT_REFRESHES);

    rfs_mode_e         mode_q;
    logic [WAIT_W-1:0] wait_q;
    logic [INIT_W-1:0] init_left_q;

    logic seq_busy;
    logic init_start;
    logic accept;
    logic tick;

    // Initialization refreshes need no grant: the memory is not yet in use.
    assign init_start = (mode_q == MODE_INIT) && !seq_busy && (init_left_q != '0);
    assign ref_req    = (mode_q == MODE_RUN) && !seq_busy && (backlog != '0);
    assign accept     = ref_req && ref_gnt;
    assign ready      = (mode_q == MODE_RUN);

    // The write strobe is never driven low: a low level ahead of the row
    // strobe fall would turn a refresh into a test-mode entry (R7).
    assign we_n = 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q      <= MODE_WAIT;
            wait_q      <= '0;
            init_left_q <= INIT_LOAD;
        end else begin
            case (mode_q)
                MODE_WAIT: begin
                    if (wait_q == WAIT_LAST) begin
                        mode_q <= MODE_INIT;
                    end else begin
                        wait_q <= wait_q + 1'b1;
                    end
                end
                MODE_INIT: begin
                    if (init_start) begin
                        init_left_q <= init_left_q - 1'b1;
                    end
                    if ((init_left_q == '0) && !seq_busy) begin
                        mode_q <= MODE_RUN;
                    end
                end
                default: mode_q <= MODE_RUN;
            endcase
        end
    end

    rfs_tick_gen #(
        .INTERVAL (REFRESH_INTERVAL)
    ) u_tick (
        .clk    (clk),
        .rst    (rst),
        .enable (ready),
        .tick   (tick)
    );

    rfs_backlog #(
        .DEBT_W (DEBT_W),
        .MISS_W (MISS_W)
    ) u_backlog (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .take   (accept),
        .debt   (backlog),
        .missed (missed_total)
    );

    rfs_cbr_seq #(
        .SETUP_CYC   (SETUP_CYC),
        .HOLD_CYC    (HOLD_CYC),
        .RAS_LOW_CYC (RAS_LOW_CYC),
        .PRECH_CYC   (PRECH_CYC)
    ) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (init_start || accept),
        .busy  (seq_busy),
        .ras_n (ras_n),
        .cas_n (cas_n)
    );

endmodule

// File: rtl/rfs_sched_chk.sv
module rfs_sched_chk #(
    parameter int unsigned DEBT_W = 4,
    parameter int unsigned MISS_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ref_gnt,
    input logic              ref_req,
    input logic              ready,
    input logic              ras_n,
    input logic              cas_n,
    input logic [DEBT_W-1:0] backlog,
    input logic [MISS_W-1:0] missed_total
);

    assert_cas_falls_first_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(cas_n) |-> ras_n);

    assert_cas_low_before_ras_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> ($past(cas_n) == 1'b0));

    assert_cas_release_under_ras_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(cas_n) |-> !ras_n);

    assert_ras_release_cas_high_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |-> cas_n);

    assert_ready_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);

    assert_req_needs_ready_R8: assert property (@(posedge clk) disable iff (rst)
        ref_req |-> (ready && (backlog != '0)));

    assert_grant_starts_refresh_R9: assert property (@(posedge clk) disable iff (rst)
        (ref_req && ref_gnt) |=> (!ref_req && !cas_n));

    assert_backlog_step_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(backlog) == '0) || (backlog >= $past(backlog) - 1'b1));

    assert_missed_monotonic_R11: assert property (@(posedge clk) disable iff (rst)
        missed_total >= $past(missed_total));

endmodule

bind dram_refresh_sched rfs_sched_chk #(
    .DEBT_W (DEBT_W),
    .MISS_W (MISS_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ref_gnt      (ref_gnt),
    .ref_req      (ref_req),
    .ready        (ready),
    .ras_n        (ras_n),
    .cas_n        (cas_n),
    .backlog      (backlog),
    .missed_total (missed_total)
);

// File: tb/dram_refresh_sched_tb.sv
module dram_refresh_sched_tb;

    localparam int STARTUP = 100;
    localparam int NINIT   = 8;
    localparam int IV      = 400;
    localparam int SU      = 1;
    localparam int HO      = 2;
    localparam int RASL    = 9;
    localparam int PRE     = 7;
    localparam int DW      = 4;
    localparam int MW      = 8;
    localparam int PERIOD  = SU + RASL + PRE + 1;

    // {expiries with grant withheld, expected miss-count increase}
    localparam int NVEC = 4;
    localparam int VEC [NVEC][2] = '{'{1, 0}, '{2, 1}, '{3, 2}, '{6, 5}};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ref_gnt = 1'b0;
    logic          ref_req, ready, ras_n, cas_n, we_n;
    logic [DW-1:0] backlog;
    logic [MW-1:0] missed_total;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  we_bad = 1'b0;
    bit  req_early = 1'b0;

    always #4 clk = ~clk;

    dram_refresh_sched #(
        .STARTUP_CYCLES   (STARTUP),
        .INIT_REFRESHES   (NINIT),
        .REFRESH_INTERVAL (IV),
        .SETUP_CYC        (SU),
        .HOLD_CYC         (HO),
        .RAS_LOW_CYC      (RASL),
        .PRECH_CYC        (PRE),
        .DEBT_W           (DW),
        .MISS_W           (MW)
    ) u_dut (
        .clk          (clk),
        .rst          (rst),
        .ref_gnt      (ref_gnt),
        .ref_req      (ref_req),
        .ready        (ready),
        .ras_n        (ras_n),
        .cas_n        (cas_n),
        .we_n         (we_n),
        .backlog      (backlog),
        .missed_total (missed_total)
    );

    // Sticky port monitors for R7 and R3.
    always @(negedge clk) begin
        if (!rst) begin
            if (!we_n) we_bad = 1'b1;
            if (ref_req && !ready) req_early = 1'b1;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    // Entered at the negedge where cas_n has just fallen.
    task automatic one_refresh(output int su, output int ho, output int ac);
        su = 0; ho = 0; ac = 0;
        while (!cas_n && ras_n) begin su++; @(negedge clk); end
        while (!cas_n && !ras_n) begin ho++; @(negedge clk); end
        while (cas_n && !ras_n) begin ac++; @(negedge clk); end
    endtask

    // Wait for backlog to reach k with the grant held low; check spacing.
    task automatic accumulate(input int k);
        int prev = int'(backlog);
        int last = -1;
        int c = 0;
        while ((int'(backlog) != k) && (c < (k + 1) * IV + 50)) begin
            @(negedge clk);
            c++;
            if (int'(backlog) == prev + 1) begin
                if (last >= 0) chk((c - last) == IV, "R8 expiry spacing", c - last, IV);
                last = c;
            end
            prev = int'(backlog);
        end
    endtask

    // Grant is raised at this negedge; count refreshes until drained.
    task automatic drain(input int k);
        int  falls = 1;
        int  g = 0;
        bit  ingap = 1'b0;
        logic prev_cas;
        ref_gnt = 1'b1;
        @(negedge clk);
        chk(cas_n == 1'b0, "R9 refresh starts after grant", cas_n, 0);
        chk(ref_req == 1'b0, "R9 request drops after grant", ref_req, 0);
        chk(int'(backlog) == k - 1, "R9 backlog taken", backlog, k - 1);
        prev_cas = cas_n;
        repeat (k * PERIOD + 30) begin
            @(negedge clk);
            if (prev_cas && !cas_n) begin
                falls++;
                if (ingap) chk(g == PRE + 1, "R10 back-to-back gap", g, PRE + 1);
                ingap = 1'b0;
                g = 0;
            end
            if (ras_n && cas_n) begin
                g = ingap ? g + 1 : 1;
                ingap = 1'b1;
            end
            prev_cas = cas_n;
        end
        chk(falls == k, "R10 refreshes to drain", falls, k);
        chk(backlog == '0, "R10 backlog drained", backlog, 0);
        ref_gnt = 1'b0;
    endtask

    initial begin
        int n;
        int su, ho, ac, g;
        int m0;

        // R1: reset state
        repeat (4) @(negedge clk);
        chk(ras_n && cas_n && we_n, "R1 strobes high in reset", {ras_n, cas_n, we_n}, 7);
        chk(!ready && !ref_req, "R1 ready/req low in reset", {ready, ref_req}, 0);
        chk(backlog == '0 && missed_total == '0, "R1 counters clear", backlog + missed_total, 0);
        rst = 1'b0;

        // R2: start-up silence
        n = 0;
        while (cas_n && n < 10000) begin
            @(negedge clk);
            n++;
            if (!ras_n) chk(1'b0, "R2 ras_n during delay", n, 0);
        end
        chk(n == STARTUP + 1, "R2 first cas_n fall cycle", n, STARTUP + 1);

        // R3..R6: initialization burst, no grant
        for (int i = 0; i < NINIT; i++) begin
            one_refresh(su, ho, ac);
            chk(su == SU, "R4 setup length", su, SU);
            chk(ho == HO, "R5 hold length", ho, HO);
            chk(ac == RASL - HO, "R5 ras-only low length", ac, RASL - HO);
            g = 0;
            while (ras_n && cas_n && !ready && g < 1000) begin g++; @(negedge clk); end
            chk(g == PRE + 1, "R6 precharge gap", g, PRE + 1);
            if (i < NINIT - 1) begin
                chk(!ready && !cas_n, "R3 next init refresh", ready, 0);
            end else begin
                chk(ready && cas_n && ras_n, "R3 ready after last init refresh", ready, 1);
            end
        end
        chk(!req_early, "R3 no request before ready", req_early, 0);

        // R8..R11: table of withheld-grant scenarios
        for (int v = 0; v < NVEC; v++) begin
            m0 = int'(missed_total);
            accumulate(VEC[v][0]);
            chk(int'(backlog) == VEC[v][0], "R8 backlog reached", backlog, VEC[v][0]);
            chk(ref_req == 1'b1, "R8 request with backlog", ref_req, 1);
            chk(int'(missed_total) - m0 == VEC[v][1], "R11 miss count", int'(missed_total) - m0, VEC[v][1]);
            drain(VEC[v][0]);
        end

        // R12: saturation after 18 withheld expiries
        m0 = int'(missed_total);
        accumulate(15);
        repeat (3 * IV + 5) @(negedge clk);
        chk(int'(backlog) == 15, "R12 backlog saturated", backlog, 15);
        chk(int'(missed_total) - m0 == 17, "R12 R11 misses past saturation", int'(missed_total) - m0, 17);
        drain(15);

        chk(ready == 1'b1, "R3 ready stays high", ready, 1);
        chk(!we_bad, "R7 we_n always high", we_bad, 0);
        summary();
        $finish;
    end

endmodule